// File: doc/BRIEF.md
# Payload Type Mismatch Interrupt Unit

This unit sits on the receive side of an E3 framer. The framer front end extracts a 3-bit payload type from each received frame. It presents that field together with a one-cycle frame-valid strobe. The unit stores the value of every strobed frame. It compares the value with an expected payload type that the host has programmed. On a mismatch it sets a sticky status bit, and that bit pulls an active-low interrupt request when its enable is on.

The host reaches the unit over a simple byte-wide register port. That port has a write strobe, a read strobe, an address and write data, and returns registered read data. The configuration register at 0x10 holds the expected payload type. It also reports the last received type and two algorithm-status inputs. The interrupt-enable register at 0x13 holds the mismatch enable in bit 0. It also stores enables for other receive alarms that live outside this unit. The interrupt status register at 0x15 reports the sticky mismatch bit in bit 0, and reading it clears the bit.

Top module: `ptm_irq_unit`

## Requirements
- R1: After reset, reads of 0x10, 0x13 and 0x15 return 0x00, `mis_sts` is 0 and `irq_n` is 1.
- R2: A write to 0x10 stores wdata[2:0] as the expected payload type, which reads back at bits 2:0 of 0x10. Write data bits 7:3 have no effect on what 0x10 reads back.
- R3: Bits 7:5 of 0x10 show the payload type of the most recent frame sampled with `frm_vld`=1. They keep their value while `frm_vld` is 0.
- R4: Bit 4 of 0x10 reads `ferf_alg` and bit 3 reads `tmark_alg`, each as sampled on the previous clock edge.
- R5: A frame whose payload type equals the expected type does not set the mismatch status.
- R6: A frame whose payload type differs from the expected type sets `mis_sts` at the clock edge that samples the frame, whether the enable is on or off.
- R7: 0x13 stores bits 6, 4, 3, 2, 1 and 0 of the write data. Bits 7 and 5 always read 0.
- R8: `irq_n` is 0 exactly when `mis_sts` is 1 and bit 0 of 0x13 is 1. Otherwise it is 1.
- R9: A read of 0x15 returns `mis_sts` in bit 0, with bits 7:1 at 0, and clears the status at that edge.
- R10: When a mismatching frame and a read of 0x15 fall in the same cycle, the status stays 1 and the read returns the value the status had before that edge.
- R11: A read of any address other than 0x10, 0x13 and 0x15 returns 0x00. Writes to 0x15 and to unused addresses change no register.
- R12: A frame that arrives in the same cycle as a write to 0x10 is compared with the expected type held before the write.
- R13: `rdata` loads on the clock edge at which `rd_en` is 1. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| frm_vld | input | 1 | One-cycle strobe per received frame |
| frm_ptype | input | 3 | Payload type extracted from the frame |
| ferf_alg | input | 1 | Far-end receive failure algorithm status |
| tmark_alg | input | 1 | Timing marker algorithm status |
| mis_sts | output | 1 | Sticky mismatch status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two operations can hit the same status bit in one cycle. A mismatching frame can arrive in the same cycle as the host's clear-on-read of 0x15, and a frame can be compared in the same cycle as a write that changes the expected type. The bench drives each collision on purpose and also lets random traffic produce them. A behavioural model in the bench decides the outcome: the set wins over the clear, the read shows the old status, and the comparison uses the old expected value. Every clock, the model's read data, status and request are compared with the ports.

// File: rtl/ptm_pkg.sv
// Package: shared constants for the payload type mismatch interrupt unit.
// Assumes an 8-bit register data path and a 3-bit payload type field.
package ptm_pkg;
    localparam int DATA_W = 8;
    localparam int PT_W   = 3;

    localparam logic [7:0] ADR_CFG = 8'h10;
    localparam logic [7:0] ADR_IEN = 8'h13;
    localparam logic [7:0] ADR_ISR = 8'h15;

    // Writable bits of the interrupt-enable register
    localparam logic [DATA_W-1:0] IEN_MASK = 8'h5F;
endpackage

// File: rtl/ptm_detect.sv
// Module: per-frame payload type capture and mismatch status.
// Samples the received type on frm_vld. Sets a sticky status bit on a
// mismatch against the expected type. The status is cleared by a host read
// strobe, and a set in the same cycle wins. Drives the gated active-low request.
// Assumes frm_vld is a single-cycle strobe in the clk domain.
module ptm_detect
    import ptm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_vld,
    input  logic [PT_W-1:0] frm_ptype,
    input  logic [PT_W-1:0] exp_pt,
    input  logic            mis_en,
    input  logic            rd_clr,
    output logic [PT_W-1:0] pt_q,
    output logic            sts,
    output logic            irq_n
);
    logic mismatch;

    // Compare the incoming frame's type with the expected value
    always_comb mismatch = frm_vld && (frm_ptype != exp_pt);

    // Capture the last received payload type
    always_ff @(posedge clk) begin
        if (!rst_n)       pt_q <= '0;
        else if (frm_vld) pt_q <= frm_ptype;
    end

    // Sticky status: set on mismatch, cleared by the status read
    always_ff @(posedge clk) begin
        if (!rst_n)        sts <= 1'b0;
        else if (mismatch) sts <= 1'b1;
        else if (rd_clr)   sts <= 1'b0;
    end

    // Request pulls low while an enabled status is pending
    always_comb irq_n = !(sts && mis_en);

    AST_SET_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_ptype != exp_pt) |=> sts); // R6
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(frm_vld && frm_ptype != exp_pt)); // R5
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !frm_vld) |=> !sts); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && frm_vld && frm_ptype != exp_pt) |=> sts); // R10
    AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(pt_q)); // R3
endmodule

// File: rtl/ptm_regs.sv
// Module: host register file and read-back path.
// Holds the expected payload type, the interrupt enables and the sampled
// algorithm-status inputs. Returns registered read data and produces the
// clear strobe for the status register.
// Assumes single-cycle wr_en/rd_en strobes with addr and wdata stable alongside.
module ptm_regs
    import ptm_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ferf_alg,
    input  logic              tmark_alg,
    input  logic [PT_W-1:0]   pt_q,
    input  logic              sts,
    output logic [PT_W-1:0]   exp_pt,
    output logic [DATA_W-1:0] ien,
    output logic              rd_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADR_CFG);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(ADR_IEN);
    localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(ADR_ISR);

    logic              ferf_q;
    logic              tmark_q;
    logic [DATA_W-1:0] rd_mux;

    // Expected payload type register
    always_ff @(posedge clk) begin
        if (!rst_n)                      exp_pt <= '0;
        else if (wr_en && addr == A_CFG) exp_pt <= wdata[PT_W-1:0];
    end

    // Interrupt-enable register, unused bits held at zero
    always_ff @(posedge clk) begin
        if (!rst_n)                      ien <= '0;
        else if (wr_en && addr == A_IEN) ien <= wdata & IEN_MASK;
    end

    // Sample the algorithm-status inputs every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferf_q  <= 1'b0;
            tmark_q <= 1'b0;
        end else begin
            ferf_q  <= ferf_alg;
            tmark_q <= tmark_alg;
        end
    end

    // Read-back selection by address
    always_comb begin
        unique case (addr)
            A_CFG:   rd_mux = {pt_q, ferf_q, tmark_q, exp_pt};
            A_IEN:   rd_mux = ien;
            A_ISR:   rd_mux = {{(DATA_W-1){1'b0}}, sts};
            default: rd_mux = '0;
        endcase
    end

    // Status clears when its register is read
    always_comb rd_clr = rd_en && (addr == A_ISR);

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_EXP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG) |=> exp_pt == $past(wdata[PT_W-1:0])); // R2
    AST_IEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_IEN) |=> ien == $past(wdata & IEN_MASK)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R13
endmodule

// File: rtl/ptm_irq_unit.sv
// Module: top of the payload type mismatch interrupt unit.
// Joins the host register file to the frame-level detector. The request is
// gated by bit 0 of the interrupt-enable register.
// Assumes a single clock domain and a synchronous active-low reset.
module ptm_irq_unit
    import ptm_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              frm_vld,
    input  logic [PT_W-1:0]   frm_ptype,
    input  logic              ferf_alg,
    input  logic              tmark_alg,
    output logic              mis_sts,
    output logic              irq_n
);
    logic [PT_W-1:0]   exp_pt;
    logic [PT_W-1:0]   pt_q;
    logic [DATA_W-1:0] ien;
    logic              rd_clr;

    ptm_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .ferf_alg  (ferf_alg),
        .tmark_alg (tmark_alg),
        .pt_q      (pt_q),
        .sts       (mis_sts),
        .exp_pt    (exp_pt),
        .ien       (ien),
        .rd_clr    (rd_clr),
        .rdata     (rdata)
    );

    ptm_detect i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm_ptype (frm_ptype),
        .exp_pt    (exp_pt),
        .mis_en    (ien[0]),
        .rd_clr    (rd_clr),
        .pt_q      (pt_q),
        .sts       (mis_sts),
        .irq_n     (irq_n)
    );

    AST_IRQ_MEANS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> mis_sts); // R8
endmodule

// File: tb/test_ptm_irq_unit.sv
// Bench: a behavioural reference model, compared with the ports on every clock,
// plus directed checks for each requirement.
module test_ptm_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, frm_vld = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [2:0] frm_ptype = '0;
    logic       ferf_alg = 1'b0, tmark_alg = 1'b0;
    logic [7:0] rdata;
    logic       mis_sts, irq_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit running = 1'b0;
    bit done = 1'b0;

    // model state
    int m_exp = 0, m_pt = 0, m_ferf = 0, m_tmark = 0, m_en = 0, m_sts = 0, m_rdata = 0;

    always #2.5 clk = ~clk;

    ptm_irq_unit i_ptm_irq_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .frm_vld(frm_vld), .frm_ptype(frm_ptype),
        .ferf_alg(ferf_alg), .tmark_alg(tmark_alg), .mis_sts(mis_sts), .irq_n(irq_n)
    );

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        int rv, nsts;
        if (!rst_n) begin
            m_exp = 0; m_pt = 0; m_ferf = 0; m_tmark = 0; m_en = 0; m_sts = 0; m_rdata = 0;
        end else begin
            case (addr)
                8'h10:   rv = (m_pt << 5) | (m_ferf << 4) | (m_tmark << 3) | m_exp;
                8'h13:   rv = m_en;
                8'h15:   rv = m_sts;
                default: rv = 0;
            endcase
            nsts = m_sts;
            if (rd_en && addr == 8'h15) nsts = 0;
            if (frm_vld && int'(frm_ptype) != m_exp) nsts = 1;
            if (rd_en) m_rdata = rv;
            if (frm_vld) m_pt = frm_ptype;
            if (wr_en && addr == 8'h10) m_exp = wdata % 8;
            if (wr_en && addr == 8'h13) m_en = wdata & 8'h5F;
            m_ferf = ferf_alg;
            m_tmark = tmark_alg;
            m_sts = nsts;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the model
    always @(negedge clk) begin
        if (running) begin
            chk({cur_req, " rdata"}, rdata, m_rdata);
            chk({cur_req, " mis_sts"}, mis_sts, m_sts);
            chk({cur_req, " irq_n"}, irq_n, (m_sts & m_en & 1) ? 0 : 1);
        end
    end

    // One bus/frame cycle, started and ended at a falling edge
    task automatic op(input bit w, input bit r, input int a, input int d,
                      input bit f, input int p);
        wr_en = w; rd_en = r; addr = a[7:0]; wdata = d[7:0];
        frm_vld = f; frm_ptype = p[2:0];
        @(negedge clk);
        wr_en = 0; rd_en = 0; frm_vld = 0;
    endtask

    task automatic rd(input int a);
        op(0, 1, a, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        op(1, 0, a, d, 0, 0);
    endtask

    task automatic frame(input int p);
        op(0, 0, 0, 0, 1, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        cur_req = "R1";
        chk("R1 irq_n", irq_n, 1); chk("R1 mis_sts", mis_sts, 0);
        rd(8'h10); chk("R1 cfg", rdata, 8'h00);
        rd(8'h13); chk("R1 ien", rdata, 8'h00);
        rd(8'h15); chk("R1 isr", rdata, 8'h00);

        cur_req = "R2";
        wr(8'h10, 8'hFD); rd(8'h10); chk("R2 expected", rdata, 8'h05);

        cur_req = "R4";
        ferf_alg = 1; op(0, 0, 0, 0, 0, 0); rd(8'h10); chk("R4 ferf", rdata, 8'h15);
        ferf_alg = 0; tmark_alg = 1; op(0, 0, 0, 0, 0, 0); rd(8'h10); chk("R4 tmark", rdata, 8'h0D);
        tmark_alg = 0; op(0, 0, 0, 0, 0, 0);

        cur_req = "R5";
        frame(5); chk("R5 match status", mis_sts, 0); chk("R5 irq_n", irq_n, 1);
        rd(8'h10); chk("R5 type field", rdata, 8'hA5);

        cur_req = "R3";
        op(0, 0, 0, 0, 0, 2); rd(8'h10); chk("R3 hold without strobe", rdata, 8'hA5);

        cur_req = "R6";
        frame(2); chk("R6 status disabled", mis_sts, 1); chk("R6 irq_n disabled", irq_n, 1);
        rd(8'h10); chk("R6 type field", rdata, 8'h45);

        cur_req = "R7";
        wr(8'h13, 8'hFF); rd(8'h13); chk("R7 ien", rdata, 8'h5F);
        cur_req = "R8";
        chk("R8 irq low", irq_n, 0);
        wr(8'h13, 8'h5E); chk("R8 irq masked", irq_n, 1);
        wr(8'h13, 8'h01); chk("R8 irq re-enabled", irq_n, 0);

        cur_req = "R9";
        rd(8'h15); chk("R9 read", rdata, 8'h01); chk("R9 cleared", mis_sts, 0);
        chk("R9 irq high", irq_n, 1);
        rd(8'h15); chk("R9 second read", rdata, 8'h00);

        cur_req = "R10";
        frame(3); chk("R10 set", mis_sts, 1);
        op(0, 1, 8'h15, 0, 1, 1); chk("R10 rdata", rdata, 8'h01); chk("R10 set wins", mis_sts, 1);
        rd(8'h15); chk("R10 cleared after", mis_sts, 0);
        frame(6); op(0, 1, 8'h15, 0, 1, 5);
        chk("R10 match+read clears", mis_sts, 0); chk("R10 rdata old", rdata, 8'h01);

        cur_req = "R12";
        op(1, 0, 8'h10, 3, 1, 3); chk("R12 old expected used", mis_sts, 1);
        rd(8'h15); frame(3); chk("R12 new expected used", mis_sts, 0);

        cur_req = "R11";
        rd(8'h20); chk("R11 unused", rdata, 8'h00);
        wr(8'h15, 8'hFF); chk("R11 isr write ignored", mis_sts, 0);
        wr(8'h11, 8'hFF); rd(8'h10); chk("R11 cfg intact", rdata, 8'h63);
        rd(8'h13); chk("R11 ien intact", rdata, 8'h01);

        cur_req = "R13";
        rd(8'h10); op(0, 0, 8'h13, 0, 0, 0); frame(7);
        chk("R13 rdata held", rdata, 8'h63);

        cur_req = "R10 R12 random";
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            ferf_alg = 1'($urandom_range(0, 1));
            tmark_alg = 1'($urandom_range(0, 1));
            op(1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 2) == 0),
               (sel == 0) ? 8'h10 : (sel == 1) ? 8'h13 : (sel == 2) ? 8'h15 : 8'h07,
               int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 7)));
        end

        running = 0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule